// File: doc/BRIEF.md
# Page-Mode DRAM Sequencer

This block sits between a simple request port and an asynchronous page-mode DRAM of 256K words by 8 bits that has a shared 9-bit address bus. Each request carries an 18-bit word address and a byte of write data. The controller splits the address into a row half (upper 9 bits), which is presented when the row strobe falls, and a column half (lower 9 bits), which is presented before the column strobe falls. It drives the active-low row, column, write-enable and output-enable strobes from registers, so every strobe edge lines up with a clock edge.

After an access the row stays open. A later request to the same row needs only a fresh column pulse. A request to another row first closes the open row, and the controller waits out the precharge and row-cycle minimums before it opens the new one. Four datasheet minimums (row-to-data, row cycle, column-to-data and column cycle) and a precharge time are given in nanoseconds. They are turned into clock counts by rounding up against the clock-period parameter. An interval timer asks for refresh, and refresh wins over any waiting request. A refresh is a row-strobe-only cycle on a row counter that steps through every row in turn.

Reads use late output enable: the output enable goes low one cycle after the column strobe. A per-request flag picks early write (write enable low before the column strobe falls) or late write (write enable low one cycle after it falls).

Top module: `dram_fpm_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, all four strobes are high, `dram_dq_oe` is low and `rd_valid` is low.
- R2: The row strobe falls with `req_addr[17:9]` on `dram_addr`. The column strobe falls later, with `req_addr[8:0]` on `dram_addr`, and only while the row strobe was already low in the previous cycle.
- R3: A request to the row that is already open, with no refresh since the last access, gets only a new column pulse with no new row-strobe fall. A request to a different row, or the first one after a refresh, gets a new row-strobe fall.
- R4: Between two falls of the row strobe there are at least ceil(110 ns / period) cycles. Before each fall the row strobe has been high for at least ceil(40 ns / period) cycles.
- R5: Between two falls of the column strobe there are at least ceil(35 ns / period) cycles.
- R6: Read data is sampled on the clock edge where the column strobe rises. By that edge the column strobe has been low for at least ceil(15 ns / period) cycles and the row strobe for at least ceil(60 ns / period) cycles. `rd_valid` is high for exactly one cycle with that byte on `rd_data`.
- R7: On a read, output enable falls in a cycle after the column strobe has fallen, never in the same cycle or before it.
- R8: A write with `req_late`=0 drives `dram_dq_oe`=1 with the data and pulls write enable low before the column strobe falls. Output enable stays high during the write.
- R9: A write with `req_late`=1 pulls write enable low only after the column strobe has fallen, with the data already driven.
- R10: A refresh comes due every `REF_INTERVAL` cycles. It is a row-strobe-only cycle (column strobe high) whose row address starts at 0 and goes up by one each time, wrapping after 511. The row strobe stays low for at least ceil(60 ns / period) cycles.
- R11: A due refresh is served ahead of waiting requests. Under back-to-back same-row traffic, two refreshes are never more than `REF_INTERVAL` plus a few access times apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_late | input | 1 | For writes: 1 = late write strobe, 0 = early |
| req_addr | input | 18 | Word address: row in bits 17:9, column in bits 8:0 |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 8 | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_dq_out | output | 8 | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Data output enable |
| dram_dq_in | input | 8 | Data from the DRAM |

## Verification
The controller is driven with runs of same-row writes and reads, which should produce column pulses only. It is also driven with reads that alternate between two distant rows, which force a close and reopen on every access. Together these separate page-hit tracking from row-cycle and precharge timing. Early and late writes go to the same rows, and the read-back data shows whether each strobe order actually stored the byte. The first and last addresses exercise the split of the address into its two halves. A long run of same-row reads followed by an idle stretch shows that refresh interrupts an open page, steps through rows in order and also fires when no traffic is present. A behavioural DRAM model holds data as high-impedance until its access minimums have passed, so a read sampled too early returns a wrong value.

// File: rtl/dram_fpm_pkg.sv
package dram_fpm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,    // no row open, row strobe high
        ST_OPEN,    // row open, column strobe high
        ST_ROW,     // row strobe just fell, move to column address
        ST_COL,     // column address on bus, wait for column cycle
        ST_STROBE,  // first cycle with column strobe low
        ST_WAIT,    // wait for data-access minimums
        ST_REF      // row-only refresh cycle
    } fpm_state_e;

    localparam int TM_RAS_FALL = 0;
    localparam int TM_RAS_RISE = 1;
    localparam int TM_CAS_FALL = 2;
    localparam int TM_COUNT    = 3;

    function automatic int ns_to_cycles(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_fpm_elapsed.sv
module dram_fpm_elapsed #(
    parameter int LIMIT = 8,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] SAT = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    // Cycles spent since the last restart, counting the current cycle; saturates.
    always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = CW'(1);
        end else if (cnt_q < SAT) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= SAT;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/dram_fpm_refresh.sv
module dram_fpm_refresh #(
    parameter int INTERVAL = 780,
    parameter int ROW_W    = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    output logic             pend,
    output logic [ROW_W-1:0] row
);
    localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

    typedef struct packed {
        logic [TW-1:0]    tick;
        logic             pend;
        logic [ROW_W-1:0] row;
    } ref_t;

    ref_t r_d, r_q;
    logic wrap;

    always_comb begin
        r_d  = r_q;
        wrap = (r_q.tick == LAST);
        r_d.tick = wrap ? '0 : r_q.tick + 1'b1;
        r_d.pend = wrap | (r_q.pend & ~ack);
        if (ack) begin
            r_d.row = r_q.row + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pend = r_q.pend;
    assign row  = r_q.row;

    AST_ACK_ONLY_WHEN_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> pend); // R10

endmodule

// File: rtl/dram_fpm_ctrl.sv
module dram_fpm_ctrl
    import dram_fpm_pkg::*;
#(
    parameter int ADDR_W        = 18,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 20,
    parameter int T_RAC_NS      = 60,
    parameter int T_RC_NS       = 110,
    parameter int T_CAC_NS      = 15,
    parameter int T_PC_NS       = 35,
    parameter int T_RP_NS       = 40,
    parameter int REF_INTERVAL  = 780
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic                req_late,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data,
    output logic                dram_ras_n,
    output logic                dram_cas_n,
    output logic                dram_we_n,
    output logic                dram_oe_n,
    output logic [ADDR_W/2-1:0] dram_addr,
    output logic [DATA_W-1:0]   dram_dq_out,
    output logic                dram_dq_oe,
    input  logic [DATA_W-1:0]   dram_dq_in
);
    localparam int MUX_W = ADDR_W / 2;
    localparam int ROW_W = MUX_W;
    localparam int COL_W = MUX_W;

    localparam int N_RAC = ns_to_cycles(T_RAC_NS, CLK_PERIOD_NS);
    localparam int N_RC  = ns_to_cycles(T_RC_NS,  CLK_PERIOD_NS);
    localparam int N_CAC = ns_to_cycles(T_CAC_NS, CLK_PERIOD_NS);
    localparam int N_PC  = ns_to_cycles(T_PC_NS,  CLK_PERIOD_NS);
    localparam int N_RP  = ns_to_cycles(T_RP_NS,  CLK_PERIOD_NS);
    localparam int N_MAX = max_of(max_of(max_of(N_RAC, N_RC), max_of(N_CAC, N_PC)), N_RP);
    localparam int CW    = $clog2(N_MAX + 1);

    localparam logic [CW-1:0] C_RAC = CW'(N_RAC);
    localparam logic [CW-1:0] C_RC  = CW'(N_RC);
    localparam logic [CW-1:0] C_CAC = CW'(N_CAC);
    localparam logic [CW-1:0] C_PC  = CW'(N_PC);
    localparam logic [CW-1:0] C_RP  = CW'(N_RP);

    typedef struct packed {
        fpm_state_e       st;
        logic             ras_n;
        logic             cas_n;
        logic             we_n;
        logic             oe_n;
        logic [MUX_W-1:0] ma;
        logic [DATA_W-1:0] wdat;
        logic             dq_oe;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             wr;
        logic             late;
        logic             rvalid;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{st: ST_IDLE, ras_n: 1'b1, cas_n: 1'b1,
                                   we_n: 1'b1, oe_n: 1'b1, default: '0};

    ctl_t r_d, r_q;

    // Elapsed-cycle timers: one per strobe edge that a minimum is measured from.
    logic [TM_COUNT-1:0] tm_restart;
    logic [CW-1:0]       tm_count [TM_COUNT];

    for (genvar g = 0; g < TM_COUNT; g++) begin : g_tm
        dram_fpm_elapsed #(.LIMIT(N_MAX), .CW(CW)) u_tm (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (tm_restart[g]),
            .count   (tm_count[g])
        );
    end

    logic             ref_pend;
    logic             ref_ack;
    logic [ROW_W-1:0] ref_row;

    dram_fpm_refresh #(.INTERVAL(REF_INTERVAL), .ROW_W(ROW_W)) u_refresh (
        .clk   (clk),
        .rst_n (rst_n),
        .ack   (ref_ack),
        .pend  (ref_pend),
        .row   (ref_row)
    );

    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic             row_ok;
    logic             page_hit;

    assign req_row = req_addr[ADDR_W-1:COL_W];
    assign req_col = req_addr[COL_W-1:0];

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = 1'b0;
        tm_restart = '0;
        ref_ack    = 1'b0;
        req_ready  = 1'b0;
        row_ok     = (tm_count[TM_RAS_FALL] >= C_RC) && (tm_count[TM_RAS_RISE] >= C_RP);
        page_hit   = (req_row == r_q.row);

        case (r_q.st)
            ST_IDLE: begin
                if (ref_pend) begin
                    if (row_ok) begin
                        r_d.ras_n = 1'b0;
                        r_d.ma    = ref_row;
                        tm_restart[TM_RAS_FALL] = 1'b1;
                        r_d.st    = ST_REF;
                    end
                end else if (row_ok) begin
                    req_ready = 1'b1;
                    if (req_valid) begin
                        r_d.ras_n = 1'b0;
                        r_d.ma    = req_row;
                        r_d.row   = req_row;
                        r_d.col   = req_col;
                        r_d.wr    = req_write;
                        r_d.late  = req_late;
                        r_d.wdat  = req_wdata;
                        tm_restart[TM_RAS_FALL] = 1'b1;
                        r_d.st    = ST_ROW;
                    end
                end
            end
            ST_OPEN: begin
                if (ref_pend || (req_valid && !page_hit)) begin
                    r_d.ras_n = 1'b1;
                    tm_restart[TM_RAS_RISE] = 1'b1;
                    r_d.st    = ST_IDLE;
                end else begin
                    req_ready = 1'b1;
                    if (req_valid) begin
                        r_d.ma    = req_col;
                        r_d.col   = req_col;
                        r_d.wr    = req_write;
                        r_d.late  = req_late;
                        r_d.wdat  = req_wdata;
                        r_d.dq_oe = req_write;
                        r_d.we_n  = !(req_write && !req_late);
                        r_d.st    = ST_COL;
                    end
                end
            end
            ST_ROW: begin
                r_d.ma    = r_q.col;
                r_d.dq_oe = r_q.wr;
                r_d.we_n  = !(r_q.wr && !r_q.late);
                r_d.st    = ST_COL;
            end
            ST_COL: begin
                if (tm_count[TM_CAS_FALL] >= C_PC) begin
                    r_d.cas_n = 1'b0;
                    tm_restart[TM_CAS_FALL] = 1'b1;
                    r_d.st    = ST_STROBE;
                end
            end
            ST_STROBE: begin
                if (!r_q.wr) begin
                    r_d.oe_n = 1'b0;
                end else if (r_q.late) begin
                    r_d.we_n = 1'b0;
                end
                r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if ((tm_count[TM_CAS_FALL] >= C_CAC) && (tm_count[TM_RAS_FALL] >= C_RAC)) begin
                    r_d.cas_n = 1'b1;
                    r_d.oe_n  = 1'b1;
                    r_d.we_n  = 1'b1;
                    r_d.dq_oe = 1'b0;
                    if (!r_q.wr) begin
                        r_d.rvalid = 1'b1;
                        r_d.rdata  = dram_dq_in;
                    end
                    r_d.st = ST_OPEN;
                end
            end
            ST_REF: begin
                if (tm_count[TM_RAS_FALL] >= C_RAC) begin
                    r_d.ras_n = 1'b1;
                    tm_restart[TM_RAS_RISE] = 1'b1;
                    ref_ack   = 1'b1;
                    r_d.st    = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= CTL_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign dram_ras_n  = r_q.ras_n;
    assign dram_cas_n  = r_q.cas_n;
    assign dram_we_n   = r_q.we_n;
    assign dram_oe_n   = r_q.oe_n;
    assign dram_addr   = r_q.ma;
    assign dram_dq_out = r_q.wdat;
    assign dram_dq_oe  = r_q.dq_oe;
    assign rd_valid    = r_q.rvalid;
    assign rd_data     = r_q.rdata;

    AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n); // R2
    AST_ROW_CYCLE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> ($past(tm_count[TM_RAS_FALL]) >= C_RC)); // R4
    AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> ($past(tm_count[TM_RAS_RISE]) >= C_RP)); // R4
    AST_COLUMN_CYCLE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> ($past(tm_count[TM_CAS_FALL]) >= C_PC)); // R5
    AST_READ_DATA_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (($past(tm_count[TM_CAS_FALL]) >= C_CAC) && ($past(tm_count[TM_RAS_FALL]) >= C_RAC))); // R6
    AST_RVALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R6
    AST_OE_AFTER_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_oe_n) |-> ($past(!dram_cas_n) && !dram_cas_n)); // R7
    AST_WRITE_KEEPS_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> (dram_oe_n && dram_dq_oe)); // R8

endmodule

// File: tb/dram_fpm_ctrl_bench.sv
module dram_fpm_ctrl_bench;
    localparam int PER     = 20;
    localparam int T_RAC   = 60;
    localparam int T_RC    = 110;
    localparam int T_CAC   = 15;
    localparam int T_PC    = 35;
    localparam int T_RP    = 40;
    localparam int REF_INT = 150;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0, req_late = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       req_ready, rd_valid;
    logic [7:0] rd_data;
    logic       dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [8:0] dram_addr;
    logic [7:0] dram_dq_out, dram_dq_in;
    logic [7:0] dq_model = 'z;

    always #(PER/2) clk = ~clk;
    assign dram_dq_in = dq_model;

    dram_fpm_ctrl #(.CLK_PERIOD_NS(PER), .REF_INTERVAL(REF_INT)) u_dram_fpm_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_late(req_late), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference state: DRAM array contents, expected traffic and strobe history.
    logic [7:0] mem [int];
    logic [7:0] shadow [int];
    int     exp_rd[$];
    int     exp_wr_addr[$];
    int     exp_wr_data[$];
    bit     exp_wr_late[$];
    longint t_rf = -100000, t_rr = -100000, t_cf = -100000, t_last_ref = -1;
    bit     p_ras = 1, p_cas = 1, p_oe = 1, p_rv = 0;
    int     cur_row = 0, cur_col = 0, prev_acc_row = -1, exp_ref_row = 0, n_refresh = 0;
    bit     cas_in_ras = 0, ref_since = 0, wrote = 0, we_at_fall = 0, oe_seen = 0;

    always @(negedge clk) begin
        longint now;
        int     a, ea, ed, er;
        bit     el, exp_new;
        now = $time;
        if (!rst_n) begin
            p_ras = 1; p_cas = 1; p_oe = 1; p_rv = 0;
            dq_model <= 'z;
        end else begin
            if (p_ras && !dram_ras_n) begin
                chk(now - t_rf >= T_RC, "R4", "row cycle ns", now - t_rf, T_RC);
                chk(now - t_rr >= T_RP, "R4", "precharge ns", now - t_rr, T_RP);
                cur_row = int'(dram_addr);
                cas_in_ras = 0;
                t_rf = now;
            end
            if (!p_ras && dram_ras_n) begin
                if (!cas_in_ras) begin
                    n_refresh++;
                    chk(cur_row == exp_ref_row, "R10", "refresh row", cur_row, exp_ref_row);
                    chk(now - t_rf >= T_RAC, "R10", "refresh low ns", now - t_rf, T_RAC);
                    if (t_last_ref >= 0)
                        chk(now - t_last_ref <= (REF_INT + 30) * PER, "R11", "refresh gap ns",
                            now - t_last_ref, (REF_INT + 30) * PER);
                    t_last_ref  = now;
                    exp_ref_row = (exp_ref_row + 1) % 512;
                    ref_since   = 1;
                end
                t_rr = now;
            end
            if (p_cas && !dram_cas_n) begin
                chk(!p_ras && !dram_ras_n, "R2", "row low before column", p_ras, 0);
                chk(now - t_cf >= T_PC, "R5", "column cycle ns", now - t_cf, T_PC);
                cur_col = int'(dram_addr);
                exp_new = ref_since || (cur_row != prev_acc_row);
                chk(exp_new == !cas_in_ras, "R3", "new row open", !cas_in_ras, exp_new);
                prev_acc_row = cur_row;
                ref_since  = 0;
                cas_in_ras = 1;
                we_at_fall = !dram_we_n;
                wrote      = 0;
                oe_seen    = 0;
                t_cf       = now;
            end
            if (!dram_cas_n && !dram_we_n && !wrote) begin
                wrote = 1;
                a = cur_row * 512 + cur_col;
                if (exp_wr_addr.size() == 0) begin
                    chk(0, "R8", "unexpected write addr", a, -1);
                end else begin
                    ea = exp_wr_addr.pop_front();
                    ed = exp_wr_data.pop_front();
                    el = exp_wr_late.pop_front();
                    chk(a == ea, "R2", "write address", a, ea);
                    chk(dram_dq_oe && int'(dram_dq_out) == ed, el ? "R9" : "R8", "write data",
                        int'(dram_dq_out), ed);
                    chk(we_at_fall == !el, el ? "R9" : "R8", "WE low at CAS fall", we_at_fall, !el);
                    chk(dram_oe_n, "R8", "OE high during write", dram_oe_n, 1);
                end
                mem[a] = dram_dq_out;
            end
            if (p_oe && !dram_oe_n) begin
                chk(!p_cas && !dram_cas_n, "R7", "CAS low before OE", p_cas, 0);
                oe_seen = 1;
            end
            if (!p_cas && dram_cas_n && oe_seen) begin
                chk(now - t_cf >= T_CAC, "R6", "CAS low ns at capture", now - t_cf, T_CAC);
                chk(now - t_rf >= T_RAC, "R6", "RAS low ns at capture", now - t_rf, T_RAC);
            end
            if (rd_valid) begin
                chk(!p_rv, "R6", "rd_valid single cycle", p_rv, 0);
                if (exp_rd.size() == 0) begin
                    chk(0, "R6", "unexpected read data", int'(rd_data), -1);
                end else begin
                    er = exp_rd.pop_front();
                    chk(rd_data === 8'(er), "R6", "read data", int'(rd_data), er);
                end
            end
            // Data becomes valid only once both access minimums are met by the next edge.
            a = cur_row * 512 + int'(dram_addr);
            if (!dram_oe_n && !dram_cas_n && (now - t_cf + PER >= T_CAC) && (now - t_rf + PER >= T_RAC))
                dq_model <= mem.exists(cur_row * 512 + cur_col) ? mem[cur_row * 512 + cur_col] : 8'h00;
            else
                dq_model <= 'z;
            p_ras = dram_ras_n;
            p_cas = dram_cas_n;
            p_oe  = dram_oe_n;
            p_rv  = rd_valid;
        end
    end

    task automatic access(input bit wr, input bit late, input int addr, input int data);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_late  = late;
        req_addr  = 18'(addr);
        req_wdata = 8'(data);
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        if (wr) begin
            shadow[addr] = 8'(data);
            exp_wr_addr.push_back(addr);
            exp_wr_data.push_back(data & 255);
            exp_wr_late.push_back(late);
        end else begin
            exp_rd.push_back(int'(shadow[addr]));
        end
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        // R1: state during reset
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1", "strobes in reset", 0, 1);
        chk(!dram_dq_oe && !rd_valid, "R1", "dq_oe/rd_valid in reset", dram_dq_oe, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1", "strobes after reset", 0, 1);

        // R8/R3: early writes to one row, then page-hit reads (R6)
        for (int c = 0; c < 4; c++) access(1, 0, 5 * 512 + c, 8'h10 + c);
        for (int c = 0; c < 4; c++) access(0, 0, 5 * 512 + c, 0);
        // R9: late writes to another row
        for (int c = 0; c < 4; c++) access(1, 1, 300 * 512 + c * 7, 8'hA0 + c);
        // R4: alternating rows force close/reopen each time
        for (int c = 0; c < 4; c++) begin
            access(0, 0, 300 * 512 + c * 7, 0);
            access(0, 0, 5 * 512 + c, 0);
        end
        // R2: address split at both ends of the range
        access(1, 0, 0, 8'h5A);
        access(1, 1, 262143, 8'hC3);
        access(0, 0, 0, 0);
        access(0, 0, 262143, 0);
        // R11: long same-row run spanning several refresh intervals
        for (int i = 0; i < 80; i++) access(0, 0, 5 * 512 + (i % 4), 0);
        // R10: refreshes with no traffic
        idle(3 * REF_INT + 50);
        access(0, 0, 262143, 0);
        access(0, 0, 0, 0);
        idle(40);

        chk(exp_rd.size() == 0, "R6", "reads outstanding", exp_rd.size(), 0);
        chk(exp_wr_addr.size() == 0, "R8", "writes outstanding", exp_wr_addr.size(), 0);
        chk(n_refresh >= 4, "R10", "refresh count", n_refresh, 4);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule